// File: doc/BRIEF.md
# Local Exclusive Access Monitor

This block tracks load-exclusive / store-exclusive pairs issued by one processor, so that software can build atomic read-modify-write sequences without masking interrupts. A load-exclusive opens a reservation on an aligned 8-byte granule. A later store-exclusive to that granule succeeds only if the reservation is still held. Every store-exclusive, successful or not, drops the reservation. An explicit clear request drops it as well, for use on exception entry or on a context switch.

The monitor only sees its own processor's traffic. A store-exclusive to shared memory that would pass locally is not settled here: it is handed to an external monitor over a valid/response handshake. The block stays busy until that monitor returns its verdict, and then passes the verdict on as the status. The block makes no memory write. The pass/fail status tells the surrounding pipeline whether the write may proceed.

Top module: `excl_mon_top`

## Requirements
- R1: After reset the monitor is open, and `busy`, `ext_req_valid` and `stat_valid` are 0.
- R2: An accepted load-exclusive (`req_kind` = 2'b01) makes the monitor exclusive and records the granule `req_addr[ADDR_W-1:3]`. A later load-exclusive while already exclusive replaces the recorded granule.
- R3: Every accepted store-exclusive (`req_kind` = 2'b10) returns the monitor to open, whatever its outcome, so a repeated store-exclusive fails.
- R4: A store-exclusive accepted while open gives `stat_valid`=1 and `stat_fail`=1 (1 = fail, 0 = pass) in the next cycle.
- R5: A store-exclusive accepted while exclusive, to the recorded granule, with `req_shared`=0, gives `stat_valid`=1 and `stat_fail`=0 in the next cycle.
- R6: A store-exclusive whose granule differs from the recorded one fails locally in the next cycle, with or without the shared attribute, and is not forwarded.
- R7: A store-exclusive accepted while exclusive, to the recorded granule, with `req_shared`=1, raises `busy` and `ext_req_valid` from the next cycle, with `ext_req_addr` equal to the request address. These stay until `ext_rsp_valid` is seen. One cycle later `stat_valid`=1, `stat_fail` equals the sampled `ext_rsp_fail`, and `busy` is 0.
- R8: An accepted clear request (`req_kind` = 2'b11) forces the monitor open in one cycle.
- R9: A plain store (`req_kind` = 2'b00) changes neither the state nor the recorded granule, and produces no status.
- R10: While `busy` is 1, requests are ignored. An `ext_rsp_valid` arriving while not busy is ignored and produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 00 plain store, 01 load-exclusive, 10 store-exclusive, 11 clear |
| req_addr | input | ADDR_W | Byte address of the request |
| req_shared | input | 1 | Target lies in shared memory |
| busy | output | 1 | A forwarded store-exclusive awaits its verdict; requests are ignored |
| stat_valid | output | 1 | One-cycle strobe carrying a store-exclusive outcome |
| stat_fail | output | 1 | Outcome: 1 fail, 0 pass (meaningful with `stat_valid`) |
| ext_req_valid | output | 1 | Request to the external monitor, held until answered |
| ext_req_addr | output | ADDR_W | Address of the forwarded store-exclusive |
| ext_rsp_valid | input | 1 | External monitor verdict present |
| ext_rsp_fail | input | 1 | External verdict: 1 fail, 0 pass |

## Verification
Directed sequences try each store-exclusive outcome on its own:
- open versus exclusive, which separates the reservation from no reservation;
- same versus neighbouring granule, with addresses chosen inside and across an 8-byte boundary, which exposes wrong tag slicing;
- shared versus non-shared, which separates local resolution from forwarding, with external verdicts of both polarities and several response delays.

Interleaved load-exclusive, plain-store and clear requests show whether each one overwrites, preserves or drops the reservation. Requests issued while busy, and stray responses, show whether anything leaks past the handshake. A long random mix over a small address window with back-to-back requests is then compared every cycle against the behavioural model.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    K_STORE = 2'b00,
    K_LDEX  = 2'b01,
    K_STEX  = 2'b10,
    K_CLEAR = 2'b11
  } req_kind_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_state_e;

  typedef enum logic [1:0] {
    V_NONE = 2'b00,
    V_PASS = 2'b01,
    V_FAIL = 2'b10,
    V_FWD  = 2'b11
  } verdict_e;

  // Granule index of a byte address: drop the offset bits inside the granule.
  function automatic logic [63:0] granule_idx(input logic [63:0] a, input int lg);
    return a >> lg;
  endfunction

  // Outcome of a store-exclusive given state, tag comparison and shared flag.
  function automatic verdict_e judge_stex(input mon_state_e st, input logic tag_hit,
                                          input logic shared);
    if (st == MON_OPEN) return V_FAIL;
    if (!tag_hit)       return V_FAIL;
    if (shared)         return V_FWD;
    return V_PASS;
  endfunction

endpackage

// File: rtl/excl_mon_track.sv
module excl_mon_track
  import excl_mon_pkg::*;
#(
  parameter int TAG_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic             close_ev,
  input  logic [TAG_W-1:0] ld_tag,
  output mon_state_e       state,
  output logic [TAG_W-1:0] tag
);

  mon_state_e       state_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MON_OPEN;
      tag_q   <= '0;
    end else if (close_ev) begin
      state_q <= MON_OPEN;
    end else if (load_ev) begin
      state_q <= MON_EXCL;
      tag_q   <= ld_tag;
    end
  end

  assign state = state_q;
  assign tag   = tag_q;

  // R2
  ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !close_ev) |=> (state == MON_EXCL && tag == $past(ld_tag)));

  // R3
  close_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_ev |=> (state == MON_OPEN));

endmodule

// File: rtl/excl_mon_judge.sv
module excl_mon_judge
  import excl_mon_pkg::*;
#(
  parameter int TAG_W = 29
) (
  input  mon_state_e       state,
  input  logic [TAG_W-1:0] held_tag,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             shared,
  output logic             tag_hit,
  output verdict_e         verdict
);

  always_comb begin
    tag_hit = (held_tag == req_tag);
    verdict = judge_stex(state, tag_hit, shared);
  end

endmodule

// File: rtl/excl_mon_fwd.sv
module excl_mon_fwd #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_addr,
  input  logic              rsp_valid,
  input  logic              rsp_fail,
  output logic              pending,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic              done,
  output logic              done_fail
);

  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (pend_q) begin
      if (rsp_valid) pend_q <= 1'b0;
    end else if (launch) begin
      pend_q <= 1'b1;
      addr_q <= launch_addr;
    end
  end

  assign pending   = pend_q;
  assign fwd_addr  = addr_q;
  assign done      = pend_q && rsp_valid;
  assign done_fail = rsp_fail;

  // R7
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !rsp_valid) |=> (pending && $stable(fwd_addr)));

  // R10
  no_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !pending);

endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GRANULE_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_shared,
  output logic              busy,
  output logic              stat_valid,
  output logic              stat_fail,
  output logic              ext_req_valid,
  output logic [ADDR_W-1:0] ext_req_addr,
  input  logic              ext_rsp_valid,
  input  logic              ext_rsp_fail
);

  localparam int TAG_W = ADDR_W - GRANULE_LG;

  req_kind_e        kind;
  logic             accept;
  logic             is_ldex, is_stex, is_clear, is_store;
  logic [TAG_W-1:0] req_tag;
  mon_state_e       state;
  logic [TAG_W-1:0] held_tag;
  logic             tag_hit;
  verdict_e         verdict;
  logic             pending, fwd_done, fwd_fail;
  logic             launch, local_done, local_fail;
  logic             sv_q, sf_q;

  assign kind     = req_kind_e'(req_kind);
  assign accept   = req_valid && !pending;
  assign is_ldex  = accept && kind == K_LDEX;
  assign is_stex  = accept && kind == K_STEX;
  assign is_clear = accept && kind == K_CLEAR;
  assign is_store = accept && kind == K_STORE;
  assign req_tag  = TAG_W'(granule_idx(64'(req_addr), GRANULE_LG));

  excl_mon_track #(.TAG_W(TAG_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_ev  (is_ldex),
    .close_ev (is_stex || is_clear),
    .ld_tag   (req_tag),
    .state    (state),
    .tag      (held_tag)
  );

  excl_mon_judge #(.TAG_W(TAG_W)) u_judge (
    .state    (state),
    .held_tag (held_tag),
    .req_tag  (req_tag),
    .shared   (req_shared),
    .tag_hit  (tag_hit),
    .verdict  (verdict)
  );

  assign launch     = is_stex && verdict == V_FWD;
  assign local_done = is_stex && verdict != V_FWD;
  assign local_fail = verdict == V_FAIL;

  excl_mon_fwd #(.ADDR_W(ADDR_W)) u_fwd (
    .clk         (clk),
    .rst_n       (rst_n),
    .launch      (launch),
    .launch_addr (req_addr),
    .rsp_valid   (ext_rsp_valid),
    .rsp_fail    (ext_rsp_fail),
    .pending     (pending),
    .fwd_addr    (ext_req_addr),
    .done        (fwd_done),
    .done_fail   (fwd_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
      sf_q <= 1'b0;
    end else begin
      sv_q <= fwd_done || local_done;
      sf_q <= fwd_done ? fwd_fail : (local_done && local_fail);
    end
  end

  assign stat_valid    = sv_q;
  assign stat_fail     = sf_q;
  assign busy          = pending;
  assign ext_req_valid = pending;

  // R4
  open_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stex && state == MON_OPEN) |=> (stat_valid && stat_fail));

  // R5
  local_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stex && state == MON_EXCL && tag_hit && !req_shared) |=> (stat_valid && !stat_fail));

  // R6
  miss_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stex && !tag_hit) |=> (stat_valid && stat_fail && !busy));

  // R7
  ext_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ext_rsp_valid) |=> (stat_valid && stat_fail == $past(ext_rsp_fail) && !busy));

  // R8
  clear_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_clear |=> (state == MON_OPEN));

  // R9
  store_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> ($stable(state) && $stable(held_tag) && !stat_valid));

  // R10
  stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && ext_rsp_valid && !is_stex) |=> !stat_valid);

endmodule

// File: tb/test_excl_mon_top.sv
module test_excl_mon_top;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_kind = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic          req_shared = 1'b0;
  logic          busy, stat_valid, stat_fail, ext_req_valid;
  logic [AW-1:0] ext_req_addr;
  logic          ext_rsp_valid = 1'b0;
  logic          ext_rsp_fail = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  string phase = "R1";

  // responder controls, written only by the stimulus
  int rsp_delay = 2;
  bit rsp_fail_sel = 1'b0;
  int stray_req = 0;
  int stray_done = 0;
  int wait_cnt = 0;

  always #2 clk = ~clk;

  excl_mon_top #(.ADDR_W(AW), .GRANULE_LG(3)) i_excl_mon_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_shared(req_shared), .busy(busy),
    .stat_valid(stat_valid), .stat_fail(stat_fail), .ext_req_valid(ext_req_valid),
    .ext_req_addr(ext_req_addr), .ext_rsp_valid(ext_rsp_valid),
    .ext_rsp_fail(ext_rsp_fail)
  );

  // behavioural reference state
  bit          m_excl = 0;
  longint      m_gran = 0;
  bit          m_pend = 0;
  logic [AW-1:0] m_paddr = '0;
  bit          m_sv = 0;
  bit          m_sf = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit nsv, nsf;
    nsv = 0; nsf = 0;
    if (!rst_n) begin
      m_excl = 0; m_gran = 0; m_pend = 0; m_paddr = '0;
    end else if (m_pend) begin
      if (ext_rsp_valid) begin nsv = 1; nsf = ext_rsp_fail; m_pend = 0; end
    end else if (req_valid) begin
      case (req_kind)
        2'b01: begin m_excl = 1; m_gran = longint'(req_addr) / 8; end
        2'b11: m_excl = 0;
        2'b10: begin
          nsv = 1;
          if (!m_excl || m_gran != longint'(req_addr) / 8) nsf = 1;
          else if (!req_shared) nsf = 0;
          else begin nsv = 0; m_pend = 1; m_paddr = req_addr; end
          m_excl = 0;
        end
        default: ;
      endcase
    end
    m_sv = nsv; m_sf = nsf;
    #1;
    chk(phase, "stat_valid", stat_valid, m_sv);
    if (m_sv) chk(phase, "stat_fail", stat_fail, m_sf);
    chk(phase, "busy", busy, m_pend);
    chk(phase, "ext_req_valid", ext_req_valid, m_pend);
    if (m_pend) chk(phase, "ext_req_addr", ext_req_addr, m_paddr);
  end

  // external monitor stand-in
  always @(negedge clk) begin
    ext_rsp_valid = 1'b0;
    if (stray_req != stray_done) begin
      stray_done = stray_req;
      ext_rsp_valid = 1'b1;
      ext_rsp_fail = 1'b0;
    end else if (!ext_req_valid) begin
      wait_cnt = 0;
    end else begin
      if (wait_cnt == rsp_delay) begin
        ext_rsp_valid = 1'b1;
        ext_rsp_fail = rsp_fail_sel;
      end
      wait_cnt++;
    end
  end

  task automatic issue(input logic [1:0] k, input logic [AW-1:0] a, input logic sh);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_shared = sh;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    phase = "R4";  issue(2'b10, 32'h104, 0); idle(2);
    phase = "R5";  issue(2'b01, 32'h100, 0); issue(2'b10, 32'h104, 0); idle(2);
    phase = "R3";  issue(2'b10, 32'h104, 0); idle(2);
    phase = "R6";  issue(2'b01, 32'h200, 0); issue(2'b10, 32'h208, 1); idle(2);
                   issue(2'b01, 32'h1ff, 0); issue(2'b10, 32'h200, 0); idle(2);
    phase = "R2";  issue(2'b01, 32'h300, 0); issue(2'b01, 32'h400, 0);
                   issue(2'b10, 32'h300, 0); idle(2);
                   issue(2'b01, 32'h300, 0); issue(2'b01, 32'h400, 0);
                   issue(2'b10, 32'h407, 0); idle(2);
    phase = "R7";  rsp_delay = 3; rsp_fail_sel = 0;
                   issue(2'b01, 32'h500, 0); issue(2'b10, 32'h503, 1); idle(8);
                   rsp_delay = 0; rsp_fail_sel = 1;
                   issue(2'b01, 32'h508, 1); issue(2'b10, 32'h50c, 1); idle(6);
    phase = "R10"; rsp_delay = 4; rsp_fail_sel = 0;
                   issue(2'b01, 32'h600, 0); issue(2'b10, 32'h600, 1);
                   issue(2'b01, 32'h700, 0); issue(2'b10, 32'h700, 0); idle(8);
                   issue(2'b10, 32'h700, 0); idle(2);
                   issue(2'b01, 32'h780, 0); stray_req++; idle(3);
                   issue(2'b10, 32'h780, 0); idle(2);
    phase = "R8";  issue(2'b01, 32'h800, 0); issue(2'b11, 32'h800, 0);
                   issue(2'b10, 32'h800, 0); idle(2);
    phase = "R9";  issue(2'b01, 32'h900, 0); issue(2'b00, 32'h900, 0);
                   issue(2'b00, 32'ha00, 1); issue(2'b10, 32'h904, 0); idle(2);

    phase = "R3";
    for (int i = 0; i < 400; i++) begin
      rsp_delay = $urandom_range(0, 3);
      rsp_fail_sel = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) req_valid = 1'b0;
      issue(2'($urandom_range(0, 3)), AW'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
    end
    idle(10);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule